// File: doc/BRIEF.md
# Glitch-free multi-output clock gate bank

This block takes one internal clock and fans it out onto six gated clock lines: five primary lines and one extra copy line. Every line can be parked low and restarted without ever producing a shortened or stretched pulse. A seventh line carries the ungated clock for an external feedback path. It keeps running through stops, disables and reset.

Each enable and the active-low global stop pass through a two-stage synchronizer clocked on the falling edge. The combined run condition for a line is then captured on a falling edge, and the clock is ANDed with that register. As a result, a line can only change state while the clock is low. The first enable input drives the first two lines as a pair, and every other line has its own enable. A global drive-enable input produces one output-enable per line for the pad tri-state drivers. It acts combinationally and does not touch the clock values.

Top module: `clkgate_bank`

## Requirements
- R1: `line_en_i[0]` controls `clk_o[0]` and `clk_o[1]` together. `line_en_i[n]` for n = 1..4 controls `clk_o[n+1]` alone, and `clk_o[5]` is the copy line.
- R2: Suppose a change on an enable or on `stop_ni` is stable over three consecutive falling edges of `clk_i`. Then from the third falling edge on, the line is held low (run condition false) or follows `clk_i` from the next rising edge (run condition true).
- R3: After reset, every high pulse on a gated line lasts exactly half a clock period. Every low pulse lasts half a period plus a whole number of periods. A gated line is low whenever `clk_i` is low.
- R4: `stop_ni` low stops all six gated lines with the R2 latency, whatever the per-line enables are. A line runs only when its enable and `stop_ni` are both high.
- R5: `fb_clk_o` equals `clk_i` at all times, including during reset, stop and disable.
- R6: `drive_en_i` low drives every bit of `clk_oe_o` to 0 and `drive_en_i` high drives every bit to 1, with no clock delay. The values on `clk_o` are not affected.
- R7: While `rst_ni` is low, all gated lines are low. The synchronizers reset to the enabled state, so with all inputs enabled the lines start running on the rising edge that follows the first falling edge after release.
- R8: Changing one line's enable does not change any other line that has a different enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_en_i | input | 5 | Per-line synchronous enables (bit 0 drives the pair) |
| stop_ni | input | 1 | Global stop, active low |
| drive_en_i | input | 1 | Global pad drive enable, low tri-states all gated lines |
| clk_o | output | 6 | Gated clock lines |
| clk_oe_o | output | 6 | Per-line output-enable for the tri-state pad drivers |
| fb_clk_o | output | 1 | Ungated feedback clock |

## Verification
The latency assertions assume that `line_en_i` and `stop_ni` are sampled cleanly at falling edges. The stimulus therefore changes them only 2 ns after a rising edge, well clear of the next falling edge. The assertions also assume reset is asserted only while `clk_i` is low or before the clock starts. An asynchronous reset in mid-high-phase would cut a pulse short, so the bench applies reset only at the start. The random phase flips enables and the stop input at random cycles against a falling-edge reference model. Every pulse width on every line is measured alongside.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int unsigned NUM_OUT_DEF = 6;
  localparam int unsigned SYNC_STAGES = 2;

  // line 0 and 1 share enable 0, line n>0 uses enable n-1
  function automatic int unsigned en_of_out(input int unsigned out_idx);
    return (out_idx == 0) ? 0 : out_idx - 1;
  endfunction
endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic gate_o,
  output logic clk_o
);
  logic gate_q;

  // captured while clk is low, so AND cannot glitch
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= run_i;
  end

  assign clk_o  = clk_i & gate_q;
  assign gate_o = gate_q;

  always_comb begin
    if (!rst_ni) AST_PARK_IN_RESET: assert (clk_o == 1'b0); // R7
  end
endmodule

// File: rtl/clkgate_bank.sv
module clkgate_bank
  import clkgate_pkg::*;
#(
  parameter int unsigned NUM_OUT = NUM_OUT_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_OUT-2:0] line_en_i,
  input  logic               stop_ni,
  input  logic               drive_en_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] clk_oe_o,
  output logic               fb_clk_o
);
  localparam int unsigned NUM_EN  = NUM_OUT - 1;
  localparam int unsigned LANES   = NUM_EN + 1;
  localparam int unsigned LAT     = SYNC_STAGES + 1;
  localparam int unsigned WARM_W  = $clog2(LAT + 1);

  logic [LANES-1:0]   lane_raw;
  logic [LANES-1:0]   lane_q;
  logic [NUM_OUT-1:0] run_d;
  logic [NUM_OUT-1:0] raw_run;
  logic [NUM_OUT-1:0] gate;

  assign lane_raw = {stop_ni, line_en_i};

  for (genvar l = 0; l < LANES; l++) begin : g_sync
    clkgate_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (lane_raw[l]),
      .q_o    (lane_q[l])
    );
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_line
    localparam int unsigned EN_IDX = en_of_out(o);
    assign run_d[o]   = lane_q[EN_IDX] & lane_q[NUM_EN];
    assign raw_run[o] = line_en_i[EN_IDX] & stop_ni;

    clkgate_cell i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_d[o]),
      .gate_o (gate[o]),
      .clk_o  (clk_o[o])
    );
  end

  assign fb_clk_o = clk_i;
  assign clk_oe_o = {NUM_OUT{drive_en_i}};

  // falling edges since reset, saturating; only guards the latency checks
  logic [WARM_W-1:0] warm_q;
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      warm_q <= '0;
    else if (warm_q != WARM_W'(LAT))  warm_q <= warm_q + 1'b1;
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_ast
    AST_RUN_LATENCY: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (warm_q == WARM_W'(LAT)) |-> gate[o] == $past(raw_run[o], LAT)); // R2
  end

  AST_STOP_PARKS: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (warm_q == WARM_W'(LAT) && !$past(stop_ni, LAT)) |-> gate == '0); // R4

  AST_PAIR_TOGETHER: assert property (@(negedge clk_i) disable iff (!rst_ni)
    gate[0] == gate[1]); // R1

  AST_FB_RUNS: assert property (@(negedge clk_i) fb_clk_o == 1'b1); // R5

  always_comb begin
    if (!drive_en_i) AST_TRISTATE_ALL: assert (clk_oe_o == '0); // R6
  end
endmodule

// File: tb/test_clkgate_bank.sv
`timescale 1ps/1ps
module test_clkgate_bank;
  localparam int NO   = 6;
  localparam int NE   = 5;
  localparam int HALF = 2500;
  localparam int PER  = 5000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] en = '1;
  logic          stop_n = 1'b1;
  logic          drive = 1'b1;
  logic [NO-1:0] clk_o, clk_oe;
  logic          fb;

  always #HALF clk = ~clk;

  clkgate_bank i_clkgate_bank (
    .clk_i(clk), .rst_ni(rst_n), .line_en_i(en), .stop_ni(stop_n),
    .drive_en_i(drive), .clk_o(clk_o), .clk_oe_o(clk_oe), .fb_clk_o(fb)
  );

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R1 mapping, R4 stop
  function automatic logic [NO-1:0] want(input logic [NE:0] lanes);
    logic [NO-1:0] r;
    for (int o = 0; o < NO; o++) r[o] = lanes[(o == 0) ? 0 : o - 1] & lanes[NE];
    return r;
  endfunction

  // reference: three falling edges from input to gate (R2)
  logic [NE:0]   m1, m2;
  logic [NO-1:0] mg;
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin m1 <= '1; m2 <= '1; mg <= '0; end
    else begin m1 <= {stop_n, en}; m2 <= m1; mg <= want(m2); end
  end

  always @(posedge clk) begin
    #1000;
    if (mon_on) begin
      for (int k = 0; k < NO; k++)
        chk(clk_o[k] === mg[k], (k < 2) ? "R1" : "R8", $sformatf("high phase line %0d", k),
            longint'(clk_o[k]), longint'(mg[k]));
      chk(fb === 1'b1, "R5", "fb high", longint'(fb), 1);
      chk(clk_oe === {NO{drive}}, "R6", "oe vector", longint'(clk_oe), longint'({NO{drive}}));
    end
  end

  always @(negedge clk) begin
    #1000;
    if (mon_on) begin
      chk(clk_o === '0, "R3", "low phase lines", longint'(clk_o), 0);
      chk(fb === 1'b0, "R5", "fb low", longint'(fb), 0);
    end
  end

  for (genvar k = 0; k < NO; k++) begin : g_pw
    longint last = 0;
    bit seen = 1'b0;
    always @(clk_o[k]) begin
      if (mon_on && seen) begin
        if (clk_o[k] === 1'b1)
          chk(($time - last) % PER == HALF, "R3", $sformatf("low width line %0d", k),
              $time - last, ($time - last) - (($time - last) % PER) + HALF);
        else
          chk(($time - last) == HALF, "R3", $sformatf("high width line %0d", k),
              $time - last, HALF);
      end
      last = $time;
      seen = 1'b1;
    end
  end

  task automatic at_high(input int n);
    repeat (n) @(posedge clk);
    #1000;
  endtask

  task automatic drive_slot;
    @(posedge clk);
    #2000;
  endtask

  initial begin
    // R7: reset state
    at_high(2);
    chk(clk_o === '0, "R7", "lines in reset", longint'(clk_o), 0);
    chk(fb === 1'b1, "R5", "fb in reset", longint'(fb), 1);
    #1000;
    rst_n = 1'b1;
    mon_on = 1'b1;
    at_high(1);
    chk(clk_o === '1, "R7", "first high after release", longint'(clk_o), 63);
    at_high(8);

    // R2: disable latency on a single line
    drive_slot; en[2] = 1'b0;
    at_high(2);
    chk(clk_o[3] === 1'b1, "R2", "still running 2nd edge", longint'(clk_o[3]), 1);
    at_high(1);
    chk(clk_o[3] === 1'b0, "R2", "parked 3rd edge", longint'(clk_o[3]), 0);
    chk(clk_o[4] === 1'b1, "R8", "neighbour unaffected", longint'(clk_o[4]), 1);
    drive_slot; en[2] = 1'b1;
    at_high(2);
    chk(clk_o[3] === 1'b0, "R2", "still parked 2nd edge", longint'(clk_o[3]), 0);
    at_high(1);
    chk(clk_o[3] === 1'b1, "R2", "resumed 3rd edge", longint'(clk_o[3]), 1);

    // R1: pair
    drive_slot; en[0] = 1'b0;
    at_high(4);
    chk(clk_o[1:0] === 2'b00, "R1", "pair parked", longint'(clk_o[1:0]), 0);
    chk(clk_o[2] === 1'b1, "R1", "line 2 independent", longint'(clk_o[2]), 1);
    drive_slot; en[0] = 1'b1;

    // R4: global stop
    drive_slot; stop_n = 1'b0;
    at_high(4);
    chk(clk_o === '0, "R4", "all stopped", longint'(clk_o), 0);
    chk(fb === 1'b1, "R5", "fb during stop", longint'(fb), 1);
    drive_slot; stop_n = 1'b1;
    at_high(4);
    chk(clk_o === '1, "R4", "all resumed", longint'(clk_o), 63);

    // R6: tri-state
    drive_slot; drive = 1'b0;
    #1;
    chk(clk_oe === '0, "R6", "oe off immediately", longint'(clk_oe), 0);
    at_high(1);
    chk(clk_o === '1, "R6", "clocks untouched", longint'(clk_o), 63);
    drive_slot; drive = 1'b1;
    #1;
    chk(clk_oe === '1, "R6", "oe on immediately", longint'(clk_oe), 63);

    // random phase
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 3000; i++) begin
      drive_slot;
      if ($urandom_range(7) == 0) en = en ^ NE'($urandom_range(31));
      if ($urandom_range(31) == 0) stop_n = ~stop_n;
      if ($urandom_range(63) == 0) drive = ~drive;
    end
    at_high(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(100000 * PER);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule